// File: doc/BRIEF.md
# Directory Coherence Cache Agent

This block sits beside a small direct-mapped cache and speaks a directory coherence protocol on its behalf. Every line is in one of four states. In Nothing the line holds no data. In Sh the line holds a clean copy that other caches may also hold, and memory agrees with it. In Ex only this cache holds the line, and it has been modified, so memory is stale. In Pending a protocol request has gone to the home directory and the reply has not yet come back.

A processor presents a load or a store and holds it until a one-cycle completion pulse. Hits complete locally. Misses and upgrades send a read or write request to the home, and the line waits in Pending until a grant arrives. The home can also send invalidations and recalls at any time. An invalidation is answered with an acknowledgement. A recall of a modified line is answered with its data.

Each line holds one data word. The low `IDX_W` bits of an address select the line and the remaining bits form the tag. Every output is registered, so a decision made at one clock edge is visible after that edge.

Top module: `coh_cache_agent`

## Requirements
- R1: After reset every line is Nothing and both the completion pulse and the outgoing message valid are low. A first access to any address therefore sends a request.
- R2: A load that misses on a Nothing line sends a read request (outgoing type 0) carrying the load address one cycle later. The line then enters Pending.
- R3: While a line is Pending, an access that maps to it produces no message and no completion.
- R4: A grant-shared (incoming type 0) or grant-exclusive (incoming type 1) that matches a Pending line installs the grant data as Sh or Ex and sends nothing. The held access is then re-evaluated and completes, and a load returns the data word.
- R5: A store that hits a Sh line sends a write request (outgoing type 1) and enters Pending. After the grant-exclusive arrives, the store completes and the line is Ex with the store data.
- R6: A store that misses sends a write request for its own address. After the grant-exclusive arrives, the store data replaces the granted word.
- R7: A store that hits an Ex line completes one cycle later with no message. A load that hits Sh or Ex also completes one cycle later with no message, and returns the word.
- R8: A miss whose victim line is Ex first sends a write-back (outgoing type 2) carrying the victim address and data. On the next cycle it sends the request for the new address.
- R9: A miss whose victim line is Sh drops the victim without any message and sends the request at once.
- R10: An invalidation (incoming type 2) is answered one cycle later with an acknowledgement (outgoing type 3) carrying the same address. A matching Sh line becomes Nothing. Ex and Pending lines are left unchanged.
- R11: A recall (incoming type 3) of a matching Ex line is answered with a data message (outgoing type 4) carrying the line's word, and the line becomes Sh. Any other recall is answered with an acknowledgement, and the line is unchanged.
- R12: A home message takes priority. A processor access in the same cycle waits and produces no completion. A grant that does not match a Pending line with the same tag changes nothing.
- R13: The completion pulse lasts one cycle. The held access is not evaluated again in the cycle the pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor access held until completion |
| cpu_write | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | ADDR_W | Word address: low IDX_W bits select the line, the rest are the tag |
| cpu_wdata | input | DATA_W | Store data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, or the stored word for a store, valid with cpu_done |
| home_in_valid | input | 1 | Message from the home is present |
| home_in_type | input | 2 | 0 grant-shared, 1 grant-exclusive, 2 invalidate, 3 recall |
| home_in_addr | input | ADDR_W | Address the home message refers to |
| home_in_data | input | DATA_W | Grant data |
| msg_out_valid | output | 1 | Outgoing message present |
| msg_out_type | output | 3 | 0 read request, 1 write request, 2 write-back, 3 acknowledge, 4 recall data |
| msg_out_addr | output | ADDR_W | Address of the outgoing message |
| msg_out_data | output | DATA_W | Data for write-back and recall data |

## Verification
The hardest case to reach is a home message that lands in the same cycle as a processor access that would otherwise hit. It has to defer the access, and the deferred access must then see the changed line. The bench first brings a line to Sh with a load. It then drives the same load and an invalidation in one cycle. It expects the acknowledgement with no completion, and on the following cycle a fresh read request. The sweep also places a mismatched grant inside every Pending window, and walks each address through upgrade, recall, eviction and invalidation. A bench model of the lines and of memory supplies every expected word.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LN_NONE = 2'd0,
    LN_SH   = 2'd1,
    LN_EX   = 2'd2,
    LN_PEND = 2'd3
  } line_st_e;

  typedef enum logic [2:0] {
    OM_RD   = 3'd0,
    OM_WR   = 3'd1,
    OM_WB   = 3'd2,
    OM_ACK  = 3'd3,
    OM_DATA = 3'd4
  } out_msg_e;

  typedef enum logic [1:0] {
    IM_GNT_SH = 2'd0,
    IM_GNT_EX = 2'd1,
    IM_INV    = 2'd2,
    IM_RECALL = 2'd3
  } in_msg_e;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  output line_st_e          rd_state,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_st_en,
  input  line_st_e          wr_state,
  input  logic              wr_tag_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_data_en,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  // per-line state registers carry the reset; tag and data stay reset-free
  for (genvar g = 0; g < LINES; g++) begin : g_line_state
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[g] <= LN_NONE;
      end else if (wr_st_en && (idx == IDX_W'(g))) begin
        st_q[g] <= wr_state;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_tag_en) tag_q[idx] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (wr_data_en) data_q[idx] <= wr_data;
  end

  assign rd_state = st_q[idx];
  assign rd_tag   = tag_q[idx];
  assign rd_data  = data_q[idx];

endmodule

// File: rtl/coh_home_resp.sv
module coh_home_resp
  import coh_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  in_msg_e           in_type,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_data,
  input  line_st_e          ln_state,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  output logic              wr_st_en,
  output line_st_e          wr_state,
  output logic              wr_data_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              out_valid,
  output out_msg_e          out_type,
  output logic [DATA_W-1:0] out_data
);
  logic tag_eq;
  assign tag_eq = (ln_tag == in_tag);

  always_comb begin
    wr_st_en   = 1'b0;
    wr_state   = LN_NONE;
    wr_data_en = 1'b0;
    wr_data    = in_data;
    out_valid  = 1'b0;
    out_type   = OM_ACK;
    out_data   = '0;
    unique case (in_type)
      IM_GNT_SH, IM_GNT_EX: begin
        if (ln_state == LN_PEND && tag_eq) begin
          wr_st_en   = 1'b1;
          wr_state   = (in_type == IM_GNT_EX) ? LN_EX : LN_SH;
          wr_data_en = 1'b1;
        end
      end
      IM_INV: begin
        out_valid = 1'b1;
        out_type  = OM_ACK;
        if (ln_state == LN_SH && tag_eq) begin
          wr_st_en = 1'b1;
          wr_state = LN_NONE;
        end
      end
      IM_RECALL: begin
        out_valid = 1'b1;
        if (ln_state == LN_EX && tag_eq) begin
          out_type = OM_DATA;
          out_data = ln_data;
          wr_st_en = 1'b1;
          wr_state = LN_SH;
        end else begin
          out_type = OM_ACK;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/coh_cpu_engine.sv
module coh_cpu_engine
  import coh_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              cpu_write,
  input  logic [TAG_W-1:0]  cpu_tag,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  line_st_e          ln_state,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              wr_st_en,
  output line_st_e          wr_state,
  output logic              wr_tag_en,
  output logic              wr_data_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              out_valid,
  output out_msg_e          out_type,
  output logic              out_victim,
  output logic [DATA_W-1:0] out_data
);
  logic hit;
  assign hit = (ln_state == LN_SH || ln_state == LN_EX) && (ln_tag == cpu_tag);

  always_comb begin
    done       = 1'b0;
    rdata      = '0;
    wr_st_en   = 1'b0;
    wr_state   = LN_NONE;
    wr_tag_en  = 1'b0;
    wr_data_en = 1'b0;
    wr_data    = cpu_wdata;
    out_valid  = 1'b0;
    out_type   = OM_RD;
    out_victim = 1'b0;
    out_data   = '0;
    if (ln_state == LN_PEND) begin
      // stalled: wait for the home reply
    end else if (hit && !cpu_write) begin
      done  = 1'b1;
      rdata = ln_data;
    end else if (hit && ln_state == LN_EX) begin
      done       = 1'b1;
      rdata      = cpu_wdata;
      wr_data_en = 1'b1;
    end else if (hit) begin
      out_valid = 1'b1;
      out_type  = OM_WR;
      wr_st_en  = 1'b1;
      wr_state  = LN_PEND;
    end else if (ln_state == LN_EX) begin
      out_valid  = 1'b1;
      out_type   = OM_WB;
      out_victim = 1'b1;
      out_data   = ln_data;
      wr_st_en   = 1'b1;
      wr_state   = LN_NONE;
    end else begin
      out_valid = 1'b1;
      out_type  = cpu_write ? OM_WR : OM_RD;
      wr_st_en  = 1'b1;
      wr_state  = LN_PEND;
      wr_tag_en = 1'b1;
    end
  end

endmodule

// File: rtl/coh_cache_agent.sv
module coh_cache_agent
  import coh_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              home_in_valid,
  input  logic [1:0]        home_in_type,
  input  logic [ADDR_W-1:0] home_in_addr,
  input  logic [DATA_W-1:0] home_in_data,
  output logic              msg_out_valid,
  output logic [2:0]        msg_out_type,
  output logic [ADDR_W-1:0] msg_out_addr,
  output logic [DATA_W-1:0] msg_out_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  idx;
  line_st_e          ln_state;
  logic [TAG_W-1:0]  ln_tag;
  logic [DATA_W-1:0] ln_data;
  logic              cpu_go;

  assign cpu_go = cpu_valid && !home_in_valid && !cpu_done;
  assign idx    = home_in_valid ? home_in_addr[IDX_W-1:0] : cpu_addr[IDX_W-1:0];

  // home responder outputs
  logic              hr_st_en, hr_data_en, hr_out_valid;
  line_st_e          hr_state;
  logic [DATA_W-1:0] hr_data, hr_out_data;
  out_msg_e          hr_out_type;

  // processor engine outputs
  logic              ce_done, ce_st_en, ce_tag_en, ce_data_en, ce_out_valid, ce_victim;
  logic [DATA_W-1:0] ce_rdata, ce_data, ce_out_data;
  line_st_e          ce_state;
  out_msg_e          ce_out_type;

  // merged line update
  logic              wr_st_en, wr_tag_en, wr_data_en;
  line_st_e          wr_state;
  logic [DATA_W-1:0] wr_data;

  coh_home_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_home_resp (
    .in_type    (in_msg_e'(home_in_type)),
    .in_tag     (home_in_addr[ADDR_W-1:IDX_W]),
    .in_data    (home_in_data),
    .ln_state   (ln_state),
    .ln_tag     (ln_tag),
    .ln_data    (ln_data),
    .wr_st_en   (hr_st_en),
    .wr_state   (hr_state),
    .wr_data_en (hr_data_en),
    .wr_data    (hr_data),
    .out_valid  (hr_out_valid),
    .out_type   (hr_out_type),
    .out_data   (hr_out_data)
  );

  coh_cpu_engine #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_cpu_engine (
    .cpu_write  (cpu_write),
    .cpu_tag    (cpu_addr[ADDR_W-1:IDX_W]),
    .cpu_wdata  (cpu_wdata),
    .ln_state   (ln_state),
    .ln_tag     (ln_tag),
    .ln_data    (ln_data),
    .done       (ce_done),
    .rdata      (ce_rdata),
    .wr_st_en   (ce_st_en),
    .wr_state   (ce_state),
    .wr_tag_en  (ce_tag_en),
    .wr_data_en (ce_data_en),
    .wr_data    (ce_data),
    .out_valid  (ce_out_valid),
    .out_type   (ce_out_type),
    .out_victim (ce_victim),
    .out_data   (ce_out_data)
  );

  always_comb begin
    if (home_in_valid) begin
      wr_st_en   = hr_st_en;
      wr_state   = hr_state;
      wr_tag_en  = 1'b0;
      wr_data_en = hr_data_en;
      wr_data    = hr_data;
    end else begin
      wr_st_en   = cpu_go && ce_st_en;
      wr_state   = ce_state;
      wr_tag_en  = cpu_go && ce_tag_en;
      wr_data_en = cpu_go && ce_data_en;
      wr_data    = ce_data;
    end
  end

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk        (clk),
    .rst        (rst),
    .idx        (idx),
    .rd_state   (ln_state),
    .rd_tag     (ln_tag),
    .rd_data    (ln_data),
    .wr_st_en   (wr_st_en),
    .wr_state   (wr_state),
    .wr_tag_en  (wr_tag_en),
    .wr_tag     (cpu_addr[ADDR_W-1:IDX_W]),
    .wr_data_en (wr_data_en),
    .wr_data    (wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_done      <= 1'b0;
      cpu_rdata     <= '0;
      msg_out_valid <= 1'b0;
      msg_out_type  <= 3'd0;
      msg_out_addr  <= '0;
      msg_out_data  <= '0;
    end else begin
      cpu_done <= cpu_go && ce_done;
      if (cpu_go && ce_done) cpu_rdata <= ce_rdata;
      if (home_in_valid) begin
        msg_out_valid <= hr_out_valid;
        msg_out_type  <= hr_out_type;
        msg_out_addr  <= home_in_addr;
        msg_out_data  <= hr_out_data;
      end else begin
        msg_out_valid <= cpu_go && ce_out_valid;
        msg_out_type  <= ce_out_type;
        msg_out_addr  <= ce_victim ? {ln_tag, idx} : cpu_addr;
        msg_out_data  <= ce_out_data;
      end
    end
  end

endmodule

// File: rtl/coh_cache_agent_chk.sv
module coh_cache_agent_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_done,
  input logic              home_in_valid,
  input logic [1:0]        home_in_type,
  input logic [ADDR_W-1:0] home_in_addr,
  input logic              msg_out_valid,
  input logic [2:0]        msg_out_type,
  input logic [ADDR_W-1:0] msg_out_addr
);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!msg_out_valid && !cpu_done));

  a_r13_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  a_r13_no_reissue: assert property (@(posedge clk) disable iff (rst)
    (cpu_done && !home_in_valid) |=> !msg_out_valid);

  a_r12_home_first: assert property (@(posedge clk) disable iff (rst)
    home_in_valid |=> !cpu_done);

  a_r4_grant_silent: assert property (@(posedge clk) disable iff (rst)
    (home_in_valid && !home_in_type[1]) |=> !msg_out_valid);

  a_r10_inv_acked: assert property (@(posedge clk) disable iff (rst)
    (home_in_valid && home_in_type == 2'd2) |=>
      (msg_out_valid && msg_out_type == 3'd3 && msg_out_addr == $past(home_in_addr)));

  a_r11_recall_answered: assert property (@(posedge clk) disable iff (rst)
    (home_in_valid && home_in_type == 2'd3) |=>
      (msg_out_valid && (msg_out_type == 3'd3 || msg_out_type == 3'd4)
       && msg_out_addr == $past(home_in_addr)));

  a_r2_type_legal: assert property (@(posedge clk) disable iff (rst)
    msg_out_valid |-> (msg_out_type <= 3'd4));

endmodule

bind coh_cache_agent coh_cache_agent_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cpu_done      (cpu_done),
  .home_in_valid (home_in_valid),
  .home_in_type  (home_in_type),
  .home_in_addr  (home_in_addr),
  .msg_out_valid (msg_out_valid),
  .msg_out_type  (msg_out_type),
  .msg_out_addr  (msg_out_addr)
);

// File: tb/test_coh_cache_agent.sv
module test_coh_cache_agent;
  localparam int NL = 4;
  localparam int NA = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [5:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic       cpu_done;
  logic [7:0] cpu_rdata;
  logic       home_in_valid = 1'b0;
  logic [1:0] home_in_type = '0;
  logic [5:0] home_in_addr = '0;
  logic [7:0] home_in_data = '0;
  logic       msg_out_valid;
  logic [2:0] msg_out_type;
  logic [5:0] msg_out_addr;
  logic [7:0] msg_out_data;

  int vectors = 0, errors = 0;
  bit ended = 0;

  // model: 0 Nothing, 1 Sh, 2 Ex, 3 Pending
  int mst [NL];
  int mtg [NL];
  int mdat[NL];
  int mem [NA];

  always #2 clk = ~clk;

  coh_cache_agent #(.ADDR_W(6), .IDX_W(2), .DATA_W(8)) i_coh_cache_agent (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .home_in_valid(home_in_valid), .home_in_type(home_in_type),
    .home_in_addr(home_in_addr), .home_in_data(home_in_data),
    .msg_out_valid(msg_out_valid), .msg_out_type(msg_out_type),
    .msg_out_addr(msg_out_addr), .msg_out_data(msg_out_data)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_obs(input string rq, input bit ev, input int et, input int ea,
                            input int ed, input bit edn, input int erd);
    logic [26:0] act, exp;
    act = {msg_out_valid, msg_out_type, msg_out_addr, msg_out_data, cpu_done, cpu_rdata};
    exp = {ev, 3'(et), 6'(ea), 8'(ed), edn, 8'(erd)};
    if (!ev) begin
      act[25:9] = '0;
      exp[25:9] = '0;
    end else if (et != 2 && et != 4) begin
      act[16:9] = '0;
      exp[16:9] = '0;
    end
    if (!edn) begin
      act[7:0] = '0;
      exp[7:0] = '0;
    end
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // grant sequence for a Pending line: idle stall, stray grant, real grant
  task automatic serve_pending(input bit w, input int a);
    int idx = a % NL;
    step();
    expect_obs("R3 pending stall", 0, 0, 0, 0, 0, 0);
    home_in_valid = 1'b1;
    home_in_type  = w ? 2'd1 : 2'd0;
    home_in_addr  = 6'(a ^ NL);
    home_in_data  = 8'(~mem[a]);
    step();
    home_in_valid = 1'b0;
    expect_obs("R12 stray grant ignored", 0, 0, 0, 0, 0, 0);
    home_in_valid = 1'b1;
    home_in_addr  = 6'(a);
    home_in_data  = 8'(mem[a]);
    step();
    home_in_valid = 1'b0;
    expect_obs("R4 grant silent", 0, 0, 0, 0, 0, 0);
    mst[idx]  = w ? 2 : 1;
    mdat[idx] = mem[a];
  endtask

  task automatic access(input bit w, input int a, input int d);
    int idx = a % NL;
    int tg  = a / NL;
    bit fin = 0;
    bit hit;
    cpu_valid = 1'b1;
    cpu_write = w;
    cpu_addr  = 6'(a);
    cpu_wdata = 8'(d);
    for (int guard = 0; guard < 8 && !fin; guard++) begin
      step();
      hit = (mst[idx] == 1 || mst[idx] == 2) && mtg[idx] == tg;
      if (hit && (!w || mst[idx] == 2)) begin
        expect_obs(w ? "R7 store hit Ex" : "R7 load hit", 0, 0, 0, 0, 1, w ? d : mdat[idx]);
        if (w) mdat[idx] = d & 255;
        fin = 1;
      end else if (hit) begin
        expect_obs("R5 upgrade request", 1, 1, a, 0, 0, 0);
        mst[idx] = 3;
        serve_pending(1, a);
      end else if (mst[idx] == 2) begin
        expect_obs("R8 write-back of Ex victim", 1, 2, mtg[idx] * NL + idx, mdat[idx], 0, 0);
        mem[mtg[idx] * NL + idx] = mdat[idx];
        mst[idx] = 0;
      end else begin
        expect_obs(w ? "R6 write miss request" : "R2 R9 read miss request", 1, w ? 1 : 0, a, 0, 0, 0);
        mst[idx] = 3;
        mtg[idx] = tg;
        serve_pending(w, a);
      end
    end
    if (!fin) begin
      vectors++;
      errors++;
      $display("FAIL R4 access never completed actual=0 expected=1");
    end
    step();
    expect_obs("R13 single completion pulse", 0, 0, 0, 0, 0, 0);
    cpu_valid = 1'b0;
  endtask

  task automatic home_msg(input int t, input int a, input int d);
    int idx = a % NL;
    bit match = (mst[idx] != 0) && mtg[idx] == a / NL;
    home_in_valid = 1'b1;
    home_in_type  = 2'(t);
    home_in_addr  = 6'(a);
    home_in_data  = 8'(d);
    step();
    home_in_valid = 1'b0;
    if (t < 2) begin
      expect_obs("R12 grant without pending ignored", 0, 0, 0, 0, 0, 0);
    end else if (t == 2) begin
      expect_obs("R10 invalidate acked", 1, 3, a, 0, 0, 0);
      if (match && mst[idx] == 1) mst[idx] = 0;
    end else if (match && mst[idx] == 2) begin
      expect_obs("R11 recall returns data", 1, 4, a, mdat[idx], 0, 0);
      mem[a] = mdat[idx];
      mst[idx] = 1;
    end else begin
      expect_obs("R11 recall of non-Ex acked", 1, 3, a, 0, 0, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin
      mst[i] = 0; mtg[i] = 0; mdat[i] = 0;
    end
    for (int i = 0; i < NA; i++) mem[i] = (i * 29 + 7) & 255;
    repeat (3) step();
    rst = 1'b0;
    expect_obs("R1 reset outputs low", 0, 0, 0, 0, 0, 0);
    step();
    expect_obs("R1 idle after reset", 0, 0, 0, 0, 0, 0);

    for (int a = 0; a < NA; a++) begin
      access(0, a, 0);                       // R2 miss, R8/R9 victim handling
      access(1, a, (a ^ 8'h5A) & 255);       // R5 upgrade
      access(1, a, (a + 8'h80) & 255);       // R7 Ex hit
      home_msg(2, a, 0);                     // R10 Ex left unchanged
      access(0, a, 0);                       // R7 reads store data
      home_msg(3, a, 0);                     // R11 recall Ex
      access(0, a, 0);                       // Sh hit
      home_msg(3, a ^ NL, 0);                // R11 recall not held
      home_msg(1, a, 8'hEE);                 // R12 stray grant
      access(0, a, 0);
      // R12: home invalidation and processor load in the same cycle
      cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = 6'(a);
      home_in_valid = 1'b1; home_in_type = 2'd2; home_in_addr = 6'(a);
      step();
      home_in_valid = 1'b0;
      expect_obs("R12 R10 invalidate wins over load", 1, 3, a, 0, 0, 0);
      mst[a % NL] = 0;
      access(0, a, 0);                       // now misses again
      home_msg(2, a, 0);                     // R10 drops Sh
      if (a % 3 == 0) access(1, a, (a * 7) & 255);  // R6 write miss
      else if (a % 3 == 1) access(0, a, 0);         // leaves Sh for R9
    end

    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule